// File: doc/BRIEF.md
# Hashed Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It is used for branches that found no entry in the target cache. The core of the block is a table of 512 two-bit saturating counters. A hash of the branch address selects one counter. The most significant bit of that counter gives the guess. A counter changes only when a branch retires and its real direction is reported on the commit port. It then moves one step toward the reported direction. Because of this, a branch that has settled into a strong state must be guessed wrong twice in a row before its guess flips.

Loop-closing branches that test the count register take a different path. For these, the table is not read. The guess is computed from the current count value alone: the branch is guessed taken unless decrementing the count gives zero.

The predict path is combinational from the address and the table contents. The commit write lands on the next rising clock edge. A guess made in the same cycle as a commit to the same entry therefore sees the old value.

Top module: `bpred_dir`

## Requirements
- R1: On a rising clock edge with `rst_n` low, every counter is set to weakly not-taken (encoding 1), so a non-count prediction made right after reset is not taken.
- R2: The table index is `addr[10:2] ^ addr[19:11]`. Address bits [1:0] and [31:20] do not affect the index, and two addresses with the same index share one counter.
- R3: The counter encoding is 0 strongly not-taken, 1 weakly not-taken, 2 weakly taken, 3 strongly taken. For a non-count branch, `pred_taken` equals bit 1 of the indexed counter.
- R4: On a clock edge with `cmt_valid` high, the counter at the commit index increments if `cmt_taken` is 1 and decrements if it is 0, saturating at 3 and at 0.
- R5: With `cmt_valid` low, no counter changes, whatever the values on `cmt_addr` and `cmt_taken`.
- R6: Starting from a strong state, one opposite outcome leaves the guess unchanged, and a second consecutive opposite outcome flips it.
- R7: When `pred_is_cnt` is 1, `pred_taken` is 1 unless `pred_count` equals 1. Any count other than 1, including 0 and all ones, gives taken. The table is not consulted.
- R8: Predict requests, count-register requests included, never change the table.
- R9: When a commit and a prediction address the same index in the same cycle, the prediction returns the counter value from before that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_addr | input | 32 | Address of the branch being predicted |
| pred_is_cnt | input | 1 | The branch tests the count register |
| pred_count | input | 32 | Current count register value |
| cmt_valid | input | 1 | A committed branch outcome is present |
| cmt_addr | input | 32 | Address of the committed branch |
| cmt_taken | input | 1 | Actual direction of the committed branch |
| pred_taken | output | 1 | Predicted direction, 1 means taken |

## Verification
The bench targets the following corner cases:
- Saturation at both ends. A counter that wraps would turn a long run of taken outcomes into a not-taken guess.
- The two-miss rule. A design without hysteresis flips its guess after a single wrong outcome.
- Address aliasing and the bits the hash ignores. A wrong hash splits entries that should share a counter, or merges entries that should stay separate.
- Count values 0, 1, 2 and all ones. An off-by-one in the terminal test shows up at exactly these values.
- Same-cycle commit and predict on one index. A design that forwards the new value gives the post-update guess.
- Commits with the valid bit low. A design that ignores the valid bit corrupts a counter the bench is watching.

// File: rtl/bpred_pkg.sv
// Shared types and helpers for the branch direction predictor.
// Assumes a two-bit counter whose MSB is the taken/not-taken guess.
package bpred_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_t;

    // One saturating step toward the observed outcome.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_ST) nxt = ctr_t'(cur + 2'd1);
        end else begin
            if (cur != CTR_SNT) nxt = ctr_t'(cur - 2'd1);
        end
        return nxt;
    endfunction

    // Direction implied by a counter state.
    function automatic logic ctr_dir(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bpred_hash.sv
// Folds a branch address into a table index by XOR of two adjacent
// IDX_W-bit fields starting above the word offset.
// Assumes ADDR_W >= 2*IDX_W + 2; bits outside both fields are ignored.
module bpred_hash #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int LO_BASE = 2;
    localparam int HI_BASE = LO_BASE + IDX_W;
    localparam int TOP     = HI_BASE + IDX_W;

    // Combine the low and high fields into the index.
    always_comb idx = addr[LO_BASE +: IDX_W] ^ addr[HI_BASE +: IDX_W];

    // Collect the address bits the hash deliberately drops.
    logic unused_addr_bits;
    if (ADDR_W > TOP) begin : g_upper
        assign unused_addr_bits = ^{addr[ADDR_W-1:TOP], addr[LO_BASE-1:0]};
    end else begin : g_noupper
        assign unused_addr_bits = ^addr[LO_BASE-1:0];
    end
endmodule

// File: rtl/bpred_ctr_table.sv
// Table of two-bit saturating counters with one combinational read port
// and one synchronous read-modify-write commit port.
// Assumes the read returns the value held before any same-cycle write.
module bpred_ctr_table
    import bpred_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_t ctr_q [DEPTH];

    // Reset every counter to weakly not-taken, else step the committed one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_WNT;
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
        end
    end

    // Present the stored counter at the predict index.
    always_comb rd_ctr = ctr_q[rd_idx];
endmodule

// File: rtl/bpred_loop_pred.sv
// Guesses a count-register branch from the count value alone:
// taken unless the decrement would land on zero.
// Assumes the count decrements by one before the test.
module bpred_loop_pred #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] count,
    output logic             taken
);
    logic [CNT_W-1:0] after_dec;

    // Form the decremented count and test it for zero.
    always_comb begin
        after_dec = count - CNT_W'(1);
        taken     = (after_dec != '0);
    end
endmodule

// File: rtl/bpred_dir.sv
// Direction predictor top: hashed two-bit counter table for ordinary
// conditional branches, count-based guess for count-register branches.
// Assumes commits arrive in retirement order, at most one per cycle.
module bpred_dir
    import bpred_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32,
    parameter int IDX_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pred_addr,
    input  logic              pred_is_cnt,
    input  logic [CNT_W-1:0]  pred_count,
    input  logic              cmt_valid,
    input  logic [ADDR_W-1:0] cmt_addr,
    input  logic              cmt_taken,
    output logic              pred_taken
);
    logic [IDX_W-1:0] p_idx;
    logic [IDX_W-1:0] c_idx;
    ctr_t             p_ctr;
    logic             loop_taken;

    bpred_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_pred (
        .addr (pred_addr),
        .idx  (p_idx)
    );

    bpred_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_cmt (
        .addr (cmt_addr),
        .idx  (c_idx)
    );

    bpred_ctr_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (p_idx),
        .rd_ctr   (p_ctr),
        .wr_en    (cmt_valid),
        .wr_idx   (c_idx),
        .wr_taken (cmt_taken)
    );

    bpred_loop_pred #(.CNT_W(CNT_W)) u_loop (
        .count (pred_count),
        .taken (loop_taken)
    );

    // Pick the count-based guess or the table guess.
    always_comb pred_taken = pred_is_cnt ? loop_taken : ctr_dir(p_ctr);
endmodule

// File: rtl/bpred_dir_chk.sv
// Port-level temporal checks for bpred_dir, attached by bind.
module bpred_dir_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] pred_addr,
    input logic              pred_is_cnt,
    input logic [CNT_W-1:0]  pred_count,
    input logic              cmt_valid,
    input logic [ADDR_W-1:0] cmt_addr,
    input logic              cmt_taken,
    input logic              pred_taken
);
    // R1: first cycle out of reset predicts not taken for table branches
    a_r1_reset_weak_nt: assert property (@(posedge clk)
        ($rose(rst_n) && !pred_is_cnt) |-> !pred_taken);

    // R7: count branches follow the terminal-count rule
    a_r7_count_rule: assert property (@(posedge clk) disable iff (!rst_n)
        pred_is_cnt |-> (pred_taken == (pred_count != CNT_W'(1))));

    // R5: with no commit, a held table query keeps its answer
    a_r5_no_commit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!cmt_valid) && $stable(pred_addr) && !pred_is_cnt && $past(!pred_is_cnt))
        |-> $stable(pred_taken));

    // R4: a confirming taken commit keeps a taken guess taken
    a_r4_taken_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && cmt_taken && cmt_addr == pred_addr && !pred_is_cnt && pred_taken)
        |=> (!$stable(pred_addr) || pred_is_cnt || pred_taken));

    // R4: a confirming not-taken commit keeps a not-taken guess not taken
    a_r4_nt_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && !cmt_taken && cmt_addr == pred_addr && !pred_is_cnt && !pred_taken)
        |=> (!$stable(pred_addr) || pred_is_cnt || !pred_taken));
endmodule

bind bpred_dir bpred_dir_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pred_addr   (pred_addr),
    .pred_is_cnt (pred_is_cnt),
    .pred_count  (pred_count),
    .cmt_valid   (cmt_valid),
    .cmt_addr    (cmt_addr),
    .cmt_taken   (cmt_taken),
    .pred_taken  (pred_taken)
);

// File: tb/tb_bpred_dir.sv
module tb_bpred_dir;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_addr = '0;
    logic        pred_is_cnt = 1'b0;
    logic [31:0] pred_count = '0;
    logic        cmt_valid = 1'b0;
    logic [31:0] cmt_addr = '0;
    logic        cmt_taken = 1'b0;
    logic        pred_taken;

    int checks = 0;
    int errors = 0;
    logic [1:0] model [512];

    bpred_dir dut (
        .clk(clk), .rst_n(rst_n), .pred_addr(pred_addr), .pred_is_cnt(pred_is_cnt),
        .pred_count(pred_count), .cmt_valid(cmt_valid), .cmt_addr(cmt_addr),
        .cmt_taken(cmt_taken), .pred_taken(pred_taken)
    );

    always #5 clk = ~clk;

    function automatic int hidx(input logic [31:0] a);
        return int'((a[10:2] ^ a[19:11]));
    endfunction

    function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
        if (t) return (c == 2'd3) ? 2'd3 : c + 2'd1;
        return (c == 2'd0) ? 2'd0 : c - 2'd1;
    endfunction

    function automatic logic exp_pred(input logic [31:0] a, input logic isc, input logic [31:0] cnt);
        if (isc) return cnt != 32'd1;
        return model[hidx(a)][1];
    endfunction

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: pred_taken=%0b expected=%0b", req, got, exp);
        end
    endtask

    // One cycle: drive at negedge, check before the edge, then mirror the commit.
    task automatic step(input string req, input logic [31:0] pa, input logic isc,
                        input logic [31:0] cnt, input logic cv, input logic [31:0] ca,
                        input logic ct);
        @(negedge clk);
        pred_addr = pa; pred_is_cnt = isc; pred_count = cnt;
        cmt_valid = cv; cmt_addr = ca; cmt_taken = ct;
        #1;
        check(req, pred_taken, exp_pred(pa, isc, cnt));
        if (cv) model[hidx(ca)] = sat(model[hidx(ca)], ct);
    endtask

    task automatic commit(input logic [31:0] a, input logic t);
        step("R4", a, 1'b0, 32'd0, 1'b1, a, t);
    endtask

    task automatic look(input string req, input logic [31:0] a);
        step(req, a, 1'b0, 32'd0, 1'b0, 32'd0, 1'b0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] a, b;
        logic [31:0] pool [8];
        void'($urandom(32'd1234));
        for (int i = 0; i < 512; i++) model[i] = 2'd1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: fresh table is weakly not-taken everywhere
        look("R1", 32'h0000_0000);
        look("R1", 32'h000F_FFFC);
        look("R1", 32'h1234_5678);

        // R3/R4/R6: one taken commit flips weak NT to weak T
        a = 32'h0000_0400;
        commit(a, 1'b1); look("R3", a);
        commit(a, 1'b1); commit(a, 1'b1); commit(a, 1'b1); look("R4", a);
        // R6: from strong taken, one miss keeps taken, second flips
        commit(a, 1'b0); look("R6", a);
        commit(a, 1'b0); look("R6", a);
        commit(a, 1'b0); commit(a, 1'b0); commit(a, 1'b0); look("R4", a);
        commit(a, 1'b1); look("R6", a);
        commit(a, 1'b1); look("R6", a);

        // R2: aliasing through the hash and ignored bits
        a = 32'h0000_0800;
        b = a ^ 32'h0000_0804;
        commit(a, 1'b1); commit(a, 1'b1);
        look("R2", b);
        look("R2", a | 32'hFFF0_0003);
        look("R2", a ^ 32'h0000_0004);

        // R5: commit port wiggles with valid low
        a = 32'h0000_1000;
        commit(a, 1'b1);
        for (int i = 0; i < 4; i++) step("R5", a, 1'b0, 32'd0, 1'b0, a, 1'b0);
        look("R5", a);

        // R7/R8: count branches at boundary values
        step("R7", a, 1'b1, 32'd0, 1'b0, 32'd0, 1'b0);
        step("R7", a, 1'b1, 32'd1, 1'b0, 32'd0, 1'b0);
        step("R7", a, 1'b1, 32'd2, 1'b0, 32'd0, 1'b0);
        step("R7", a, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'd0, 1'b0);
        b = 32'h0000_2000;
        step("R7", b, 1'b1, 32'd5, 1'b0, 32'd0, 1'b0);
        look("R8", b);

        // R9: same-cycle commit and predict see the old value
        a = 32'h0000_3000;
        step("R9", a, 1'b0, 32'd0, 1'b1, a, 1'b1);
        look("R9", a);
        step("R9", a, 1'b0, 32'd0, 1'b1, a, 1'b0);
        look("R9", a);

        // Random mix over a small address pool
        for (int i = 0; i < 8; i++) pool[i] = $urandom();
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] pa = pool[$urandom_range(0, 7)];
            logic [31:0] ca = pool[$urandom_range(0, 7)];
            logic isc = ($urandom_range(0, 7) == 0);
            logic [31:0] cnt = 32'($urandom_range(0, 3));
            step("R4", pa, isc, cnt, $urandom_range(0, 1) == 1, ca, $urandom_range(0, 1) == 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule